// File: doc/BRIEF.md
# Encoded Static-Memory Strobe Timing Generator

This block times a single chip-select access on an external asynchronous bus, for example a CompactFlash card run in true IDE mode. Software programs the timings as compact, non-linear fields: each field has a few low bits that count single clocks and one or two high bits that add a large fixed weight. The block expands these fields into clock counts and runs one access for each accepted start request. Chip select goes active in the first clock. The read or write strobe follows after the setup count and stays active for the pulse count. The access then runs to the end of its cycle count. After a read, an optional quiet gap lets the device release the data bus.

All codes and mode bits are captured on the clock that accepts a start, so software may rewrite them while an access is running. A wait-enable bit lets a slow device hold the strobe open through its ready line. A width bit picks an 8-bit or 16-bit data bus for the access and is presented to the data path for the length of that access.

Top module: `enc_strobe_timer`

## Requirements
- R1: The setup code is 6 bits. Bit 5 weighs 128 and bits 4:0 count single clocks. With `s` the decoded value, the strobe first goes active in access clock `s`, counting the clock after the accepted start as clock 0.
- R2: The pulse code is 7 bits. Bit 6 weighs 256 and bits 5:0 count single clocks. The strobe stays active for the decoded number of clocks, and a zero pulse gives no strobe.
- R3: The cycle code is 9 bits. Bits 8:7 weigh 256 and bits 6:0 count single clocks. `busy_o` stays high for the decoded cycle count, plus any wait and float clocks.
- R4: The chip-select pulse code uses the same encoding as the pulse code. `cs_n_o` is low from access clock 0 for that many clocks, capped at the access length.
- R5: With `rd_sel_i`=1 only `rd_n_o` pulses, and with `rd_sel_i`=0 only `wr_n_o` pulses. Both use the same timing, and the two strobes are never low together.
- R6: When setup plus pulse exceeds the decoded cycle, the access lasts setup plus pulse clocks. An access never lasts less than one clock.
- R7: With wait enabled, `ready_i` is sampled only in the final strobe clock. While it is low, the strobe, the chip select and the access counter freeze, and every low clock adds one clock to the access.
- R8: With wait disabled, `ready_i` has no effect on the timing.
- R9: After a read, `busy_o` stays high for a further `float_cnt_i` (0 to 15) clocks with chip select and both strobes inactive. A write has no float gap.
- R10: `wide_o` shows the width bit captured with the accepted start (1 selects 16-bit) and holds it until the next accepted start.
- R11: `done_o` is high for exactly one clock after the access and any float gap have ended, with `busy_o` already low. A start request while `busy_o` is high is ignored.
- R12: After reset, `cs_n_o`, `rd_n_o` and `wr_n_o` are high, and `busy_o`, `done_o` and `wide_o` are low.
- R13: Codes and mode bits are captured at the accepted start. Changing them during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access request, accepted when not busy |
| rd_sel_i | input | 1 | 1 selects a read access, 0 a write access |
| ready_i | input | 1 | Device ready, active high |
| wait_en_i | input | 1 | Enables stretching of the strobe by ready |
| wide_i | input | 1 | Bus width, 1 for 16-bit and 0 for 8-bit |
| setup_code_i | input | 6 | Encoded setup count |
| pulse_code_i | input | 7 | Encoded strobe pulse count |
| cycle_code_i | input | 9 | Encoded cycle count |
| cs_code_i | input | 7 | Encoded chip-select pulse count |
| float_cnt_i | input | 4 | Post-read float gap in clocks |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| wide_o | output | 1 | Bus width of the current access |
| busy_o | output | 1 | Access or float gap in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with its default parameters: a 5+1 setup split with the high bit at weight 128, a 6+1 pulse split at 256, a 7+2 cycle split at 256, a 4-bit float count and the wait logic present. With these values every high-weight range is exercised, including a setup of 129, a pulse of 258 and a cycle of 773. An access that reaches hundreds of clocks still ends well within the run. A single 10-bit counter covers both the longest cycle and the longest setup-plus-pulse sum, so these values also exercise the extension rule and the cap on chip select.

// File: rtl/esg_pkg.sv
package esg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_FLT  = 2'd2
   } esg_state_e;

   function automatic int unsigned esg_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/esg_field_decode.sv
// Expands one packed timing code: low bits count clocks, high bits sit at HI_POS.
module esg_field_decode #(
   parameter int LO_W   = 5,
   parameter int HI_W   = 1,
   parameter int HI_POS = 7,
   parameter int OUT_W  = HI_POS + HI_W
) (
   input  logic [LO_W+HI_W-1:0] code_i,
   output logic [OUT_W-1:0]     count_o
);
   localparam int CODE_W = LO_W + HI_W;

   generate
      if (LO_W < 1) begin : g_bad_lo
         $error("esg_field_decode: LO_W must be at least 1");
      end
      if (HI_W > 0 && HI_POS < LO_W) begin : g_bad_pos
         $error("esg_field_decode: high bits overlap low bits");
      end
      if (OUT_W < ((HI_W > 0) ? HI_POS + HI_W : LO_W)) begin : g_bad_out
         $error("esg_field_decode: OUT_W too narrow");
      end

      if (HI_W == 0) begin : g_linear
         assign count_o = OUT_W'(code_i);
      end else if (HI_POS == LO_W) begin : g_contig
         assign count_o = OUT_W'(code_i);
      end else begin : g_split
         assign count_o = OUT_W'({code_i[CODE_W-1:LO_W],
                                  {(HI_POS-LO_W){1'b0}},
                                  code_i[LO_W-1:0]});
      end
   endgenerate
endmodule

// File: rtl/esg_span.sv
// Turns decoded counts into the access length and the strobe and chip-select limits.
module esg_span #(
   parameter int CNT_W = 10
) (
   input  logic [CNT_W-1:0] setup_i,
   input  logic [CNT_W-1:0] pulse_i,
   input  logic [CNT_W-1:0] cycle_i,
   input  logic [CNT_W-1:0] cs_pulse_i,
   output logic [CNT_W-1:0] stb_end_o,
   output logic [CNT_W-1:0] acc_len_o,
   output logic [CNT_W-1:0] cs_end_o
);
   logic [CNT_W-1:0] longer;

   always_comb begin
      stb_end_o = setup_i + pulse_i;
      longer    = (cycle_i > stb_end_o) ? cycle_i : stb_end_o;
      acc_len_o = (longer == '0) ? CNT_W'(1) : longer;
      cs_end_o  = (cs_pulse_i < acc_len_o) ? cs_pulse_i : acc_len_o;
   end
endmodule

// File: rtl/esg_seq.sv
// Access sequencer: idle, timed access with optional ready freeze, post-read float.
module esg_seq
   import esg_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int FLT_W    = 4,
   parameter bit HAS_WAIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             rd_i,
   input  logic             wait_en_i,
   input  logic             ready_i,
   input  logic [CNT_W-1:0] stb_beg_i,
   input  logic [CNT_W-1:0] stb_end_i,
   input  logic [CNT_W-1:0] acc_len_i,
   input  logic [CNT_W-1:0] cs_end_i,
   input  logic [FLT_W-1:0] flt_i,
   output logic             cs_act_o,
   output logic             stb_act_o,
   output logic             busy_o,
   output logic             done_o
);
   esg_state_e       state_q;
   logic [CNT_W-1:0] t_q;
   logic [FLT_W-1:0] f_q;
   logic             done_q;
   logic             hold;
   logic             last_acc;

   generate
      if (HAS_WAIT) begin : g_wait
         assign hold = wait_en_i && (state_q == ST_ACC) && (stb_end_i != stb_beg_i)
                       && (t_q == stb_end_i - CNT_W'(1)) && !ready_i;
      end else begin : g_nowait
         assign hold = 1'b0;
      end
   endgenerate

   assign last_acc = (t_q == acc_len_i - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         t_q     <= '0;
         f_q     <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept_i) begin
                  state_q <= ST_ACC;
                  t_q     <= '0;
               end
            end
            ST_ACC: begin
               if (!hold) begin
                  if (last_acc) begin
                     if (rd_i && (flt_i != '0)) begin
                        state_q <= ST_FLT;
                        f_q     <= '0;
                     end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else begin
                     t_q <= t_q + CNT_W'(1);
                  end
               end
            end
            ST_FLT: begin
               if (f_q == flt_i - FLT_W'(1)) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  f_q <= f_q + FLT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_act_o  = (state_q == ST_ACC) && (t_q < cs_end_i);
   assign stb_act_o = (state_q == ST_ACC) && (t_q >= stb_beg_i) && (t_q < stb_end_i);
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;

   // R7: a low ready in the last strobe clock freezes the access counter
   p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (state_q == ST_ACC) && (t_q == $past(t_q)));
   // R11: completion is a single-clock pulse seen only once idle
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == ST_IDLE));
   // R9: float gap only follows a read and keeps the bus quiet
   p_float_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLT) |-> (!cs_act_o && !stb_act_o && rd_i));
endmodule

// File: rtl/enc_strobe_timer.sv
module enc_strobe_timer
   import esg_pkg::*;
#(
   parameter int SU_LO_W  = 5,
   parameter int SU_HI_W  = 1,
   parameter int SU_POS   = 7,
   parameter int PU_LO_W  = 6,
   parameter int PU_HI_W  = 1,
   parameter int PU_POS   = 8,
   parameter int CY_LO_W  = 7,
   parameter int CY_HI_W  = 2,
   parameter int CY_POS   = 8,
   parameter int FLT_W    = 4,
   parameter bit HAS_WAIT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       rd_sel_i,
   input  logic                       ready_i,
   input  logic                       wait_en_i,
   input  logic                       wide_i,
   input  logic [SU_LO_W+SU_HI_W-1:0] setup_code_i,
   input  logic [PU_LO_W+PU_HI_W-1:0] pulse_code_i,
   input  logic [CY_LO_W+CY_HI_W-1:0] cycle_code_i,
   input  logic [PU_LO_W+PU_HI_W-1:0] cs_code_i,
   input  logic [FLT_W-1:0]           float_cnt_i,
   output logic                       cs_n_o,
   output logic                       rd_n_o,
   output logic                       wr_n_o,
   output logic                       wide_o,
   output logic                       busy_o,
   output logic                       done_o
);
   localparam int SU_CW = SU_LO_W + SU_HI_W;
   localparam int PU_CW = PU_LO_W + PU_HI_W;
   localparam int CY_CW = CY_LO_W + CY_HI_W;
   localparam int SU_DW = (SU_HI_W > 0) ? SU_POS + SU_HI_W : SU_LO_W;
   localparam int PU_DW = (PU_HI_W > 0) ? PU_POS + PU_HI_W : PU_LO_W;
   localparam int CY_DW = (CY_HI_W > 0) ? CY_POS + CY_HI_W : CY_LO_W;
   localparam int CNT_W = int'(esg_max(CY_DW, esg_max(SU_DW, PU_DW) + 1));

   generate
      if (FLT_W < 1) begin : g_bad_flt
         $error("enc_strobe_timer: FLT_W must be at least 1");
      end
   endgenerate

   // captured access configuration
   logic [SU_CW-1:0] su_q;
   logic [PU_CW-1:0] pu_q;
   logic [CY_CW-1:0] cy_q;
   logic [PU_CW-1:0] cq_q;
   logic [FLT_W-1:0] flt_q;
   logic             rd_q, wide_q, wen_q;
   logic             accept;
   logic             busy;

   assign accept = start_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         su_q   <= '0;
         pu_q   <= '0;
         cy_q   <= '0;
         cq_q   <= '0;
         flt_q  <= '0;
         rd_q   <= 1'b0;
         wide_q <= 1'b0;
         wen_q  <= 1'b0;
      end else if (accept) begin
         su_q   <= setup_code_i;
         pu_q   <= pulse_code_i;
         cy_q   <= cycle_code_i;
         cq_q   <= cs_code_i;
         flt_q  <= float_cnt_i;
         rd_q   <= rd_sel_i;
         wide_q <= wide_i;
         wen_q  <= wait_en_i;
      end
   end

   logic [SU_DW-1:0] su_cnt;
   logic [PU_DW-1:0] pu_cnt, cq_cnt;
   logic [CY_DW-1:0] cy_cnt;

   esg_field_decode #(.LO_W(SU_LO_W), .HI_W(SU_HI_W), .HI_POS(SU_POS), .OUT_W(SU_DW))
      u_dec_setup (.code_i(su_q), .count_o(su_cnt));
   esg_field_decode #(.LO_W(PU_LO_W), .HI_W(PU_HI_W), .HI_POS(PU_POS), .OUT_W(PU_DW))
      u_dec_pulse (.code_i(pu_q), .count_o(pu_cnt));
   esg_field_decode #(.LO_W(PU_LO_W), .HI_W(PU_HI_W), .HI_POS(PU_POS), .OUT_W(PU_DW))
      u_dec_cs (.code_i(cq_q), .count_o(cq_cnt));
   esg_field_decode #(.LO_W(CY_LO_W), .HI_W(CY_HI_W), .HI_POS(CY_POS), .OUT_W(CY_DW))
      u_dec_cycle (.code_i(cy_q), .count_o(cy_cnt));

   logic [CNT_W-1:0] stb_end, acc_len, cs_end;

   esg_span #(.CNT_W(CNT_W)) u_span (
      .setup_i   (CNT_W'(su_cnt)),
      .pulse_i   (CNT_W'(pu_cnt)),
      .cycle_i   (CNT_W'(cy_cnt)),
      .cs_pulse_i(CNT_W'(cq_cnt)),
      .stb_end_o (stb_end),
      .acc_len_o (acc_len),
      .cs_end_o  (cs_end)
   );

   logic cs_act, stb_act;

   esg_seq #(.CNT_W(CNT_W), .FLT_W(FLT_W), .HAS_WAIT(HAS_WAIT)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .rd_i     (rd_q),
      .wait_en_i(wen_q),
      .ready_i  (ready_i),
      .stb_beg_i(CNT_W'(su_cnt)),
      .stb_end_i(stb_end),
      .acc_len_i(acc_len),
      .cs_end_i (cs_end),
      .flt_i    (flt_q),
      .cs_act_o (cs_act),
      .stb_act_o(stb_act),
      .busy_o   (busy),
      .done_o   (done_o)
   );

   assign cs_n_o = !cs_act;
   assign rd_n_o = !(stb_act && rd_q);
   assign wr_n_o = !(stb_act && !rd_q);
   assign wide_o = wide_q;
   assign busy_o = busy;

   // R5: never both strobes at once
   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));
   // R12: outside an access every bus control is inactive
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && rd_n_o && wr_n_o));
   // R6: the access always covers setup plus pulse
   p_len_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (acc_len >= stb_end) && (acc_len != '0));
   // R13: a start during an access leaves the captured setup untouched
   p_cfg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(su_q) && $stable(cy_q) && $stable(rd_q)));
endmodule

// File: tb/enc_strobe_timer_tb.sv
`timescale 1ns/1ps
module enc_strobe_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, rd_sel = 1'b0, ready = 1'b1, wait_en = 1'b0, wide = 1'b0;
   logic [5:0] setup_code = '0;
   logic [6:0] pulse_code = '0;
   logic [8:0] cycle_code = '0;
   logic [6:0] cs_code = '0;
   logic [3:0] float_cnt = '0;
   logic       cs_n, rd_n, wr_n, wide_o, busy, done;

   always #2 clk = ~clk;

   enc_strobe_timer u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rd_sel_i(rd_sel), .ready_i(ready),
      .wait_en_i(wait_en), .wide_i(wide), .setup_code_i(setup_code),
      .pulse_code_i(pulse_code), .cycle_code_i(cycle_code), .cs_code_i(cs_code),
      .float_cnt_i(float_cnt), .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
      .wide_o(wide_o), .busy_o(busy), .done_o(done)
   );

   typedef struct {
      int busy_len; int cs_len; int stb_start; int stb_len; bit rd; bit wide;
   } exp_t;
   exp_t exp_q[$];

   int total = 0, failed = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor
   int b_cnt = 0, cs_cnt = 0, rd_first = -1, rd_cnt = 0, wr_first = -1, wr_cnt = 0, wide_bad = 0;
   bit prev_done = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) begin
            if (!cs_n) cs_cnt++;
            if (!rd_n) begin if (rd_first < 0) rd_first = b_cnt; rd_cnt++; end
            if (!wr_n) begin if (wr_first < 0) wr_first = b_cnt; wr_cnt++; end
            if (exp_q.size() > 0 && wide_o != exp_q[0].wide) wide_bad++;
            b_cnt++;
         end
         if (done) begin
            if (exp_q.size() == 0) chk(1'b0, "R11 unexpected done", 1, 0);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(b_cnt == e.busy_len, "R3 R6 R7 R9 busy length", b_cnt, e.busy_len);
               chk(cs_cnt == e.cs_len, "R4 chip-select clocks", cs_cnt, e.cs_len);
               if (e.rd) begin
                  chk(rd_first == e.stb_start, "R1 read strobe start", rd_first, e.stb_start);
                  chk(rd_cnt == e.stb_len, "R2 R7 read strobe length", rd_cnt, e.stb_len);
                  chk(wr_cnt == 0, "R5 write strobe idle on read", wr_cnt, 0);
               end else begin
                  chk(wr_first == e.stb_start, "R1 write strobe start", wr_first, e.stb_start);
                  chk(wr_cnt == e.stb_len, "R2 R7 write strobe length", wr_cnt, e.stb_len);
                  chk(rd_cnt == 0, "R5 read strobe idle on write", rd_cnt, 0);
               end
               chk(wide_bad == 0, "R10 width held", wide_bad, 0);
               chk(busy == 1'b0, "R11 busy low at done", int'(busy), 0);
            end
            chk(!prev_done, "R11 done one clock", int'(prev_done), 0);
            b_cnt = 0; cs_cnt = 0; rd_first = -1; rd_cnt = 0; wr_first = -1; wr_cnt = 0; wide_bad = 0;
         end
         prev_done = done;
      end
   end

   // driver
   task automatic run_acc(input logic [5:0] su, input logic [6:0] pu, input logic [8:0] cy,
                          input logic [6:0] cq, input logic [3:0] fl, input bit rd, input bit wd,
                          input bit wen, input int w, input bit rdy_low, input bit poke);
      int s, p, c, q, e, sp, qe, waits, n;
      exp_t x;
      s  = int'(su[5]) * 128 + int'(su[4:0]);
      p  = int'(pu[6]) * 256 + int'(pu[5:0]);
      c  = int'(cy[8:7]) * 256 + int'(cy[6:0]);
      q  = int'(cq[6]) * 256 + int'(cq[5:0]);
      sp = s + p;
      e  = (c > sp) ? c : sp;
      if (e == 0) e = 1;
      qe = (q < e) ? q : e;
      waits = (wen && p > 0) ? w : 0;
      x.cs_len    = qe + ((p > 0 && sp - 1 < qe) ? waits : 0);
      x.stb_len   = (p > 0) ? p + waits : 0;
      x.stb_start = (p > 0) ? s : -1;
      x.busy_len  = e + waits + (rd ? int'(fl) : 0);
      x.rd = rd; x.wide = wd;
      exp_q.push_back(x);
      setup_code = su; pulse_code = pu; cycle_code = cy; cs_code = cq; float_cnt = fl;
      rd_sel = rd; wide = wd; wait_en = wen; ready = (w > 0 || rdy_low) ? 1'b0 : 1'b1;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (exp_q.size() != 0) begin
         @(negedge clk);
         n++;
         if (poke && n == 1) begin
            start = 1'b1; setup_code = 6'h3f; pulse_code = 7'h7f; cycle_code = 9'h1ff;
            cs_code = 7'h00; float_cnt = 4'hf; rd_sel = !rd; wide = !wd; wait_en = !wen;
         end
         if (poke && n == 2) start = 1'b0;
         if (w > 0 && n == sp - 1 + w) ready = 1'b1;
      end
      ready = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      chk(cs_n && rd_n && wr_n, "R12 strobes inactive in reset", int'({cs_n, rd_n, wr_n}), 7);
      chk(!busy && !done && !wide_o, "R12 flags low in reset", int'({busy, done, wide_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && cs_n, "R12 idle after reset", int'(busy), 0);

      // small write, 16-bit (R1 R2 R3 R4 R5 R10), float ignored on write (R9)
      run_acc(6'd2, 7'd3, 9'd10, 7'd8, 4'd5, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
      // same timing as a read with float gap (R5 R9)
      run_acc(6'd2, 7'd3, 9'd10, 7'd8, 4'd5, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      // setup high range 129, cycle extended to 131, cs capped (R1 R4 R6)
      run_acc({1'b1, 5'd1}, 7'd2, 9'd0, {1'b1, 6'd1}, 4'd0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      // pulse high range 258 over cycle 256 (R2 R6)
      run_acc(6'd0, {1'b1, 6'd2}, {2'b01, 7'd0}, 7'd4, 4'd0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
      // cycle high range 773 (R3)
      run_acc(6'd1, 7'd1, {2'b11, 7'd5}, 7'd3, 4'd1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      // all-zero codes: one-clock access, no strobe (R2 R6)
      run_acc(6'd0, 7'd0, 9'd0, 7'd0, 4'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      // ready stretch of 4 with cs covering strobe end (R7 R9)
      run_acc(6'd1, 7'd2, 9'd6, 7'd6, 4'd2, 1'b1, 1'b1, 1'b1, 4, 1'b0, 1'b0);
      // ready stretch of 3, cs ending before strobe end (R7 R4)
      run_acc(6'd3, 7'd2, 9'd5, 7'd2, 4'd0, 1'b0, 1'b0, 1'b1, 3, 1'b0, 1'b0);
      // ready low with wait disabled has no effect (R8)
      run_acc(6'd2, 7'd3, 9'd4, 7'd5, 4'd0, 1'b1, 1'b0, 1'b0, 0, 1'b1, 1'b0);
      // start and code changes during an access are ignored (R11 R13)
      run_acc(6'd2, 7'd3, 9'd12, 7'd9, 4'd3, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b1);
      repeat (5) @(negedge clk);
      chk(!busy && cs_n, "R11 start during access ignored", int'(busy), 0);
      chk(wide_o == 1'b1, "R10 width held after access", int'(wide_o), 1);
      // maximum float gap after read (R9)
      run_acc(6'd0, 7'd1, 9'd2, 7'd2, 4'd15, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         chk(1'b0, "R11 watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end
endmodule